// File: doc/BRIEF.md
# Strobe-Framed Serial Memory Read Master

This block lets a simple on-chip requester read bytes from a serial memory that has one data wire and three active-low strobes: chip enable, output enable and write enable. Each bit moves in its own bus cycle. A write cycle drives the data wire and pulses chip enable and write enable low. A read cycle releases the data wire and pulses chip enable and output enable low. Chip enable stays high between cycles. The protocol is static, so these gaps can last as long as needed.

The requester presents a 16-bit start address and a byte count on a valid/ready pair. The master then sends the three-cycle restart pattern: read, write a 0, read. Next it shifts out the address in 16 write cycles and collects the data in groups of 8 read cycles. It does not resend the address between bytes, because the memory advances its own address after every byte. Each finished byte is offered on a second valid/ready pair. Three parameters set the strobe setup, active width and hold, counted in system clocks. Another parameter sets the width of the byte count.

Top module: `strobe_serial_master`

## Requirements
- R1: After reset, the three strobes are high, the data line is not driven, busy and rd_valid are low, and req_ready is high.
- R2: Every accepted request starts with exactly three bus cycles: a read, then a write whose data bit is 0, then a read.
- R3: Next come exactly 16 write cycles that carry req_addr with bit 15 first. No read cycle falls between them.
- R4: In a write cycle, output enable stays high while chip enable and write enable are low, and the data line is driven for the whole active window. In a read cycle, write enable stays high while chip enable and output enable are low.
- R5: Write enable and output enable are never both low while chip enable is low.
- R6: The data line is never driven while output enable is low. It is released at least one clock before output enable falls.
- R7: Chip enable stays low for exactly PULSE_CYC clocks in every cycle. Between two cycles it stays high for at least SETUP_CYC + HOLD_CYC + 1 clocks.
- R8: Each byte is built from 8 consecutive read cycles, with the first bit read placed in bit 7. Each bit is sampled on the last clock on which output enable is low.
- R9: A request for N bytes (N >= 1) causes exactly 8*N read cycles after the address, with no further restart or address cycles. Byte i is the memory content at (start + i) modulo 512.
- R10: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data does not change. No byte is lost or overwritten, however long the stall lasts.
- R11: busy rises on the clock that accepts a request and req_ready stays low while busy is high. busy falls only after the last byte has been taken and chip enable is high again.
- R12: A request with a count of 0 sends only the restart pattern and the address, performs no data read cycle, delivers no byte, and then drops busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Master can accept a request |
| req_addr | input | 16 | Start address sent to the memory |
| req_count | input | COUNT_W | Number of bytes to read |
| rd_valid | output | 1 | A read byte is available |
| rd_ready | input | 1 | Requester takes the byte |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | A transaction is in progress |
| mem_ce_n | output | 1 | Chip enable strobe, active low |
| mem_oe_n | output | 1 | Output enable strobe, active low |
| mem_we_n | output | 1 | Write enable strobe, active low |
| mem_dq_o | output | 1 | Data line value when driven |
| mem_dq_oe | output | 1 | Data line driver enable |
| mem_dq_i | input | 1 | Data line value seen at the pin |

## Verification
The bench runs a memory model that classifies each chip-enable window as a read or a write. It checks the restart pattern and rebuilds the 16 address bits, so a swapped bit order or a missing restart read would show up as a wrong cycle kind or a wrong address. One request starts at 0x1FE and crosses the 512-byte wrap. Another uses heavy backpressure on the byte output: a design that kept reading the last bit of the next byte would overwrite the held byte or change rd_data during the stall. A zero-count request checks that no data read cycle is issued. Per-cycle checks of pulse width, gap length and data-line release catch a strobe or driver enable that is one clock off.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RST_CYCLES = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_RST  = 3'd1,
    SQ_ADDR = 3'd2,
    SQ_DATA = 3'd3,
    SQ_FIN  = 3'd4
  } seq_t;
endpackage

// File: rtl/ssm_rst_sync.sv
module ssm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_n_s <= meta_q;
    end
  end
endmodule

// File: rtl/ssm_bus_cycle.sv
module ssm_bus_cycle
  import ssm_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_wr,
  input  logic wbit,
  input  logic dq_i,
  output logic idle,
  output logic done,
  output logic bit_stb,
  output logic bit_val,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_o,
  output logic dq_oe
);
  localparam int unsigned MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int unsigned CW    = $clog2(MAX_C + 1);

  phase_t        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d, wbit_q, wbit_d;
  logic          ce_n_d, oe_n_d, we_n_d, dq_oe_d, dq_o_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    wbit_d  = wbit_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = CW'(SETUP_CYC - 1);
          wr_d    = is_wr;
          wbit_d  = wbit;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_ACT;
          cnt_d   = CW'(PULSE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACT: begin
        if (cnt_zero) begin
          phase_d = PH_HOLD;
          cnt_d   = CW'(HOLD_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // strobe values for the next clock, registered so the pins never glitch
  always_comb begin
    ce_n_d  = !(phase_d == PH_ACT);
    oe_n_d  = !((phase_d == PH_ACT) && !wr_d);
    we_n_d  = !((phase_d == PH_ACT) && wr_d);
    dq_oe_d = wr_d && (phase_d != PH_IDLE);
    dq_o_d  = dq_oe_d && wbit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      wbit_q  <= 1'b0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      dq_o    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      wbit_q  <= wbit_d;
      ce_n    <= ce_n_d;
      oe_n    <= oe_n_d;
      we_n    <= we_n_d;
      dq_oe   <= dq_oe_d;
      dq_o    <= dq_o_d;
    end
  end

  assign idle    = (phase_q == PH_IDLE);
  assign done    = (phase_q == PH_HOLD) && cnt_zero;
  assign bit_stb = (phase_q == PH_ACT) && cnt_zero && !wr_q;
  assign bit_val = dq_i;

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> (oe_n || we_n));
  p_released_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);
  p_release_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(dq_oe));
  p_write_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && oe_n && !ce_n));
endmodule

// File: rtl/ssm_seq.sv
module ssm_seq
  import ssm_pkg::*;
#(
  parameter int unsigned COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [COUNT_W-1:0] req_count,
  input  logic               tmr_idle,
  input  logic               tmr_done,
  input  logic               out_full,
  output logic               req_ready,
  output logic               busy,
  output logic               start,
  output logic               is_wr,
  output logic               wbit,
  output logic               last_bit
);
  localparam logic [3:0] ADDR_LAST = 4'(ADDR_W - 1);
  localparam logic [3:0] BIT_LAST  = 4'(BYTE_W - 1);
  localparam logic [3:0] RST_LAST  = 4'(RST_CYCLES - 1);

  seq_t               st_q, st_d;
  logic [3:0]         step_q, step_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [COUNT_W-1:0] left_q, left_d;
  logic               launched_q, launched_d;
  logic               in_cycles;

  assign in_cycles = (st_q == SQ_RST) || (st_q == SQ_ADDR) || (st_q == SQ_DATA);
  assign last_bit  = (st_q == SQ_DATA) && (step_q == BIT_LAST);

  always_comb begin
    is_wr = 1'b0;
    wbit  = 1'b0;
    unique case (st_q)
      SQ_RST:  is_wr = (step_q == 4'd1);
      SQ_ADDR: begin
        is_wr = 1'b1;
        wbit  = addr_q[ADDR_W-1];
      end
      default: is_wr = 1'b0;
    endcase
  end

  // the final bit of a byte waits until the output holder is empty
  assign start = in_cycles && tmr_idle && !launched_q && !(last_bit && out_full);

  always_comb begin
    st_d       = st_q;
    step_d     = step_q;
    addr_d     = addr_q;
    left_d     = left_q;
    launched_d = launched_q;
    if (start) launched_d = 1'b1;
    else if (tmr_done) launched_d = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (req_valid) begin
          st_d   = SQ_RST;
          step_d = '0;
          addr_d = req_addr;
          left_d = req_count;
        end
      end
      SQ_RST: begin
        if (tmr_done) begin
          if (step_q == RST_LAST) begin
            st_d   = SQ_ADDR;
            step_d = '0;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      SQ_ADDR: begin
        if (tmr_done) begin
          addr_d = {addr_q[ADDR_W-2:0], 1'b0};
          if (step_q == ADDR_LAST) begin
            step_d = '0;
            st_d   = (left_q == '0) ? SQ_FIN : SQ_DATA;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      SQ_DATA: begin
        if (tmr_done) begin
          if (step_q == BIT_LAST) begin
            left_d = left_q - 1'b1;
            step_d = '0;
            if (left_q == COUNT_W'(1)) st_d = SQ_FIN;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      SQ_FIN: begin
        if (!out_full && tmr_idle) st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      step_q     <= '0;
      addr_q     <= '0;
      left_q     <= '0;
      launched_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      step_q     <= step_d;
      addr_q     <= addr_d;
      left_q     <= left_d;
      launched_q <= launched_d;
    end
  end

  assign req_ready = (st_q == SQ_IDLE);
  assign busy      = (st_q != SQ_IDLE);

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  p_addr_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (st_q == SQ_ADDR)) |-> is_wr);
  p_fin_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_FIN) |-> !start);
endmodule

// File: rtl/ssm_byte_buf.sv
module ssm_byte_buf
  import ssm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              last_bit,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              full
);
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [BYTE_W-1:0] hold_d;
  logic              vld_d;

  always_comb begin
    sh_d   = sh_q;
    hold_d = rd_data;
    vld_d  = rd_valid;
    if (rd_valid && rd_ready) vld_d = 1'b0;
    if (bit_stb) begin
      sh_d = {sh_q[BYTE_W-3:0], bit_val};
      if (last_bit) begin
        hold_d = {sh_q, bit_val};
        vld_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      rd_data  <= hold_d;
      rd_valid <= vld_d;
    end
  end

  assign full = rd_valid;

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && last_bit) |-> !rd_valid);
endmodule

// File: rtl/strobe_serial_master.sv
module strobe_serial_master
  import ssm_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 2,
  parameter int unsigned COUNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [15:0]        req_addr,
  input  logic [COUNT_W-1:0] req_count,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [7:0]         rd_data,
  output logic               busy,
  output logic               mem_ce_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic               mem_dq_o,
  output logic               mem_dq_oe,
  input  logic               mem_dq_i
);
  logic rst_n_s;
  logic tmr_idle, tmr_done, bit_stb, bit_val;
  logic start, is_wr, wbit, last_bit, out_full;

  ssm_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  ssm_seq #(.COUNT_W(COUNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_count (req_count),
    .tmr_idle  (tmr_idle),
    .tmr_done  (tmr_done),
    .out_full  (out_full),
    .req_ready (req_ready),
    .busy      (busy),
    .start     (start),
    .is_wr     (is_wr),
    .wbit      (wbit),
    .last_bit  (last_bit)
  );

  ssm_bus_cycle #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (start),
    .is_wr   (is_wr),
    .wbit    (wbit),
    .dq_i    (mem_dq_i),
    .idle    (tmr_idle),
    .done    (tmr_done),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .ce_n    (mem_ce_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .dq_o    (mem_dq_o),
    .dq_oe   (mem_dq_oe)
  );

  ssm_byte_buf u_buf (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .last_bit (last_bit),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .full     (out_full)
  );

  p_idle_strobes_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> (mem_ce_n && !mem_dq_oe));
endmodule

// File: tb/strobe_serial_master_test.sv
module strobe_serial_master_test;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 2;
  localparam int CW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [15:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic rd_valid;
  logic rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic busy, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_o, mem_dq_oe, mem_dq_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_mode = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  strobe_serial_master #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD), .COUNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .busy(busy), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] dev_byte(input logic [8:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd29 + 16'd90;
    return t[7:0] ^ {a[8], 7'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model state
  int m_phase = 0;
  int m_acnt = 0;
  logic [15:0] m_addr16 = '0;
  logic [8:0] m_addr = '0;
  int m_bit = 0;
  int data_reads = 0;
  bit saw_rd = 0, saw_wr = 0, wval = 0;
  logic prev_ce = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;
  int low_len = 0, gap = 100;
  logic [15:0] exp_addr = '0;
  logic prev_vld = 1'b0, prev_rdy = 1'b1;
  logic [7:0] prev_data = '0;
  logic [7:0] cur_byte;

  assign cur_byte = dev_byte(m_addr);
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && m_phase == 4) ? cur_byte[7 - m_bit] : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_ready <= bp_mode ? ((cyc % 7) == 0) : 1'b1;
  end

  // protocol monitor and device model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (req_valid && req_ready) begin
        m_phase = 0; m_acnt = 0; data_reads = 0; m_bit = 0;
      end
      chk(mem_ce_n || mem_oe_n || mem_we_n, "R5", {mem_oe_n, mem_we_n}, 3);
      if (!mem_oe_n) chk(!mem_dq_oe, "R6", mem_dq_oe, 0);
      if (!mem_oe_n && prev_oe) chk(!prev_dqoe, "R6", prev_dqoe, 0);
      if (!mem_we_n) chk(mem_dq_oe && mem_oe_n, "R4", {mem_dq_oe, mem_oe_n}, 3);
      if (!mem_ce_n) begin
        if (prev_ce) chk(gap >= SETUP + HOLD + 1, "R7", gap, SETUP + HOLD + 1);
        low_len++;
        if (!mem_oe_n) saw_rd = 1;
        if (!mem_we_n) begin saw_wr = 1; wval = mem_dq_o; end
      end else begin
        if (!prev_ce) begin
          chk(low_len == PULSE, "R7", low_len, PULSE);
          chk(saw_rd != saw_wr, "R4", {saw_rd, saw_wr}, 1);
          case (m_phase)
            0, 2: begin chk(saw_rd, "R2", saw_wr, 0); m_phase++; end
            1: begin chk(saw_wr && wval == 0, "R2", {saw_wr, wval}, 2); m_phase++; end
            3: begin
              chk(saw_wr, "R3", saw_rd, 0);
              m_addr16 = {m_addr16[14:0], wval};
              m_acnt++;
              if (m_acnt == 16) begin
                chk(m_addr16 == exp_addr, "R3", m_addr16, exp_addr);
                m_addr = m_addr16[8:0];
                m_phase = 4;
              end
            end
            default: begin
              chk(saw_rd, "R9", saw_wr, 0);
              data_reads++;
              m_bit++;
              if (m_bit == 8) begin m_bit = 0; m_addr = m_addr + 9'd1; end
            end
          endcase
          gap = 0;
        end
        gap++;
        low_len = 0; saw_rd = 0; saw_wr = 0;
      end
      // scoreboard side
      if (prev_vld && !prev_rdy)
        chk(rd_valid && rd_data == prev_data, "R10", rd_data, prev_data);
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) chk(0, "R8", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R8", rd_data, e);
        end
      end
      prev_ce = mem_ce_n; prev_oe = mem_oe_n; prev_dqoe = mem_dq_oe;
      prev_vld = rd_valid; prev_rdy = rd_ready; prev_data = rd_data;
    end
  end

  task automatic run_read(input logic [15:0] a, input int n, input bit bp);
    bp_mode = bp;
    exp_addr = a;
    for (int i = 0; i < n; i++) exp_q.push_back(dev_byte(9'(a + 16'(i))));
    while (!req_ready) @(negedge clk);
    req_addr = a;
    req_count = CW'(n);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R11", {busy, req_ready}, 2);
    while (busy) @(negedge clk);
    chk(exp_q.size() == 0, "R11", exp_q.size(), 0);
    chk(mem_ce_n && !rd_valid, "R11", {mem_ce_n, rd_valid}, 2);
    chk(m_phase == 4 && m_acnt == 16, "R3", m_acnt, 16);
    if (n == 0) chk(data_reads == 0, "R12", data_reads, 0);
    else chk(data_reads == 8 * n, "R9", data_reads, 8 * n);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !busy && !rd_valid && req_ready, "R1",
        {mem_dq_oe, busy, rd_valid, req_ready}, 1);
    run_read(16'h0010, 3, 1'b0);
    run_read(16'h01FE, 4, 1'b0);
    run_read(16'hA5C3, 2, 1'b1);
    run_read(16'h0123, 0, 1'b0);
    run_read(16'h0155, 1, 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule